// File: doc/BRIEF.md
# Strobed Input Handshake Port

This block is an 8-bit input port for a slow peripheral such as a keyboard. The peripheral places a byte on its data lines and pulses an active-low strobe. While the strobe is low the port copies the data lines into a holding register. It then raises a buffer-full flag toward the peripheral, which tells the peripheral not to send another byte until the flag drops. When the interrupt enable input is high, the rising edge of the strobe also raises an interrupt request toward the CPU. The CPU collects the byte with an active-low read strobe. The falling edge of the read withdraws the interrupt request, and the rising edge (the read is complete) clears buffer-full.

All decisions are made in the system clock domain. The strobe passes through a two-flop synchroniser and the read strobe is sampled directly. A handshake state machine drives the flags and has four states. EMPTY holds no byte. LOADING is entered when the strobe falls. HELD is entered when the strobe rises. READING is entered from HELD when the read falls.

The transitions are:
- EMPTY to LOADING on a strobe fall.
- LOADING to HELD on a strobe rise.
- HELD to READING on a read fall.
- HELD to EMPTY on a read rise.
- READING to EMPTY on a read rise.
- HELD or READING to LOADING on a strobe fall, which is an overrun.

An overrun overwrites the held byte and sets a sticky overrun flag. Only reset clears that flag.

Top module: `strobed_input_port`

## Requirements
- R1: Reset clears buf_full_o, irq_o, overrun_o and the held byte, so a read after reset presents 0x00 on cpu_data_o.
- R2: While the synchronised strobe is low, the held byte follows per_data_i. cpu_data_o shows the held byte while cpu_rd_n_i is 0, and shows 0x00 while cpu_rd_n_i is 1.
- R3: A falling edge of per_stb_n_i sets buf_full_o, and buf_full_o stays 1 after the strobe returns high.
- R4: With irq_en_i = 1, irq_o sets on the rising edge of the strobe and not while the strobe is still low. irq_o never sets while buf_full_o is 0.
- R5: With irq_en_i = 0, irq_o stays 0, while latching and buf_full_o behave as in R2 and R3.
- R6: A falling edge of cpu_rd_n_i clears irq_o, and buf_full_o stays 1 while the read is low.
- R7: A rising edge of cpu_rd_n_i that ends a read of a held byte clears buf_full_o. A read while the port is empty leaves buf_full_o at 0.
- R8: A strobe fall while buf_full_o is 1 replaces the held byte with the new data and sets overrun_o.
- R9: overrun_o stays 1 through later reads and strobes until reset.
- R10: A strobe edge changes buf_full_o or irq_o on the third rising clock edge after the input changes (two synchroniser flops plus the state flop). A read edge takes effect on the first rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| per_data_i | input | 8 | Peripheral data lines |
| per_stb_n_i | input | 1 | Peripheral strobe, active low, asynchronous |
| buf_full_o | output | 1 | Buffer-full flag to the peripheral, active high |
| cpu_rd_n_i | input | 1 | CPU read strobe, active low, synchronous to clk |
| cpu_data_o | output | 8 | Held byte during a read, 0x00 otherwise |
| irq_o | output | 1 | Interrupt request to the CPU, active high |
| irq_en_i | input | 1 | Interrupt enable |
| overrun_o | output | 1 | Sticky overrun flag |

## Verification
The assertions assume three things about the inputs:
- The peripheral holds its data stable from the strobe fall until two clock cycles after the strobe rises, which covers the synchroniser delay.
- Each strobe pulse stays low for at least three clock cycles.
- The read strobe is synchronous and is never asserted while the state machine is in LOADING.

The stimulus keeps to these limits. Strobes are held low for three to five cycles. New data appears only after the strobe has been high for three cycles. Reads are issued only after a strobe has completed. Random overruns come from a second strobe issued before the read.

// File: rtl/sip_pkg.sv
package sip_pkg;
    typedef enum logic [1:0] {
        HS_EMPTY   = 2'd0,
        HS_LOADING = 2'd1,
        HS_HELD    = 2'd2,
        HS_READING = 2'd3
    } hs_state_t;
endpackage

// File: rtl/sip_sync.sv
module sip_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    generate
        if (STAGES <= 1) begin : g_single
            logic q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q <= RST_VAL;
                else        q <= async_i;
            end
            assign sync_o = q;
        end else begin : g_chain
            logic [STAGES-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q <= {STAGES{RST_VAL}};
                else        q <= {q[STAGES-2:0], async_i};
            end
            assign sync_o = q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/sip_edge.sv
module sip_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic stb_sync_n,
    input  logic rd_n,
    output logic stb_fall,
    output logic stb_rise,
    output logic rd_fall,
    output logic rd_rise
);
    logic stb_prev_n;
    logic rd_prev_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stb_prev_n <= 1'b1;
            rd_prev_n  <= 1'b1;
        end else begin
            stb_prev_n <= stb_sync_n;
            rd_prev_n  <= rd_n;
        end
    end

    assign stb_fall = stb_prev_n & ~stb_sync_n;
    assign stb_rise = ~stb_prev_n & stb_sync_n;
    assign rd_fall  = rd_prev_n & ~rd_n;
    assign rd_rise  = ~rd_prev_n & rd_n;
endmodule

// File: rtl/sip_latch.sv
module sip_latch #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [DATA_W-1:0] din,
    input  logic              rd_n,
    output logic [DATA_W-1:0] dout
);
    logic [DATA_W-1:0] held_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       held_q <= '0;
        else if (load_en) held_q <= din;
    end

    assign dout = rd_n ? '0 : held_q;
endmodule

// File: rtl/sip_hs_fsm.sv
module sip_hs_fsm
    import sip_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stb_fall,
    input  logic stb_rise,
    input  logic rd_fall,
    input  logic rd_rise,
    input  logic irq_en_i,
    output logic buf_full_o,
    output logic irq_o,
    output logic overrun_o
);
    hs_state_t state_q, state_d;
    logic      full_q, irq_q, ovr_q;
    logic      ovr_evt;
    logic      irq_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HS_EMPTY: begin
                if (stb_fall) state_d = HS_LOADING;
            end
            HS_LOADING: begin
                if (stb_rise) state_d = HS_HELD;
            end
            HS_HELD: begin
                if (stb_fall)     state_d = HS_LOADING;
                else if (rd_fall) state_d = HS_READING;
                else if (rd_rise) state_d = HS_EMPTY;
            end
            HS_READING: begin
                if (stb_fall)     state_d = HS_LOADING;
                else if (rd_rise) state_d = HS_EMPTY;
            end
            default: state_d = HS_EMPTY;
        endcase
    end

    assign ovr_evt = stb_fall && ((state_q == HS_HELD) || (state_q == HS_READING));

    always_comb begin
        if ((state_q == HS_LOADING) && stb_rise && irq_en_i)
            irq_d = 1'b1;
        else if ((state_d == HS_HELD) && !rd_fall)
            irq_d = irq_q;
        else
            irq_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= HS_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            irq_q  <= 1'b0;
            ovr_q  <= 1'b0;
        end else begin
            full_q <= (state_d != HS_EMPTY);
            irq_q  <= irq_d;
            ovr_q  <= ovr_q | ovr_evt;
        end
    end

    assign buf_full_o = full_q;
    assign irq_o      = irq_q;
    assign overrun_o  = ovr_q;

    // R3
    full_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(buf_full_o) |-> $past(stb_fall));
    // R7
    full_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(buf_full_o) |-> $past(rd_rise));
    // R4
    irq_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> buf_full_o);
    // R5
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> ($past(irq_en_i) && $past(stb_rise)));
    // R6
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_o) |-> ($past(rd_fall) || $past(rd_rise) || $past(stb_fall)));
    // R8
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun_o) |-> ($past(buf_full_o) && $past(stb_fall)));
    // R9
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_o |=> overrun_o);
endmodule

// File: rtl/strobed_input_port.sv
module strobed_input_port #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] per_data_i,
    input  logic              per_stb_n_i,
    output logic              buf_full_o,
    input  logic              cpu_rd_n_i,
    output logic [DATA_W-1:0] cpu_data_o,
    output logic              irq_o,
    input  logic              irq_en_i,
    output logic              overrun_o
);
    logic stb_sync_n;
    logic stb_fall, stb_rise, rd_fall, rd_rise;

    sip_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_stb_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (per_stb_n_i),
        .sync_o  (stb_sync_n)
    );

    sip_edge u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .stb_sync_n (stb_sync_n),
        .rd_n       (cpu_rd_n_i),
        .stb_fall   (stb_fall),
        .stb_rise   (stb_rise),
        .rd_fall    (rd_fall),
        .rd_rise    (rd_rise)
    );

    sip_latch #(.DATA_W(DATA_W)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (~stb_sync_n),
        .din     (per_data_i),
        .rd_n    (cpu_rd_n_i),
        .dout    (cpu_data_o)
    );

    sip_hs_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .stb_fall   (stb_fall),
        .stb_rise   (stb_rise),
        .rd_fall    (rd_fall),
        .rd_rise    (rd_rise),
        .irq_en_i   (irq_en_i),
        .buf_full_o (buf_full_o),
        .irq_o      (irq_o),
        .overrun_o  (overrun_o)
    );
endmodule

// File: tb/tb_strobed_input_port.sv
`timescale 1ns/1ps
module tb_strobed_input_port;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] per_data = '0;
    logic         stb_n = 1'b1;
    logic         rd_n = 1'b1;
    logic         irq_en = 1'b0;
    logic         buf_full, irq, ovr;
    logic [W-1:0] cpu_data;

    int n_chk = 0;
    int n_bad = 0;

    logic         exp_full = 1'b0;
    logic         exp_ovr  = 1'b0;
    logic [W-1:0] exp_data = '0;

    always #2.5 clk = ~clk;

    strobed_input_port dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .per_data_i (per_data),
        .per_stb_n_i(stb_n),
        .buf_full_o (buf_full),
        .cpu_rd_n_i (rd_n),
        .cpu_data_o (cpu_data),
        .irq_o      (irq),
        .irq_en_i   (irq_en),
        .overrun_o  (ovr)
    );

    function automatic logic model_ovr(input logic prev_ovr, input logic prev_full);
        return prev_ovr | prev_full;
    endfunction

    function automatic logic model_irq(input logic en);
        return en;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        per_data = W'($urandom);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        exp_full = 1'b0;
        exp_ovr  = 1'b0;
        exp_data = '0;
        @(negedge clk);
        check("R1 buf_full after reset", buf_full, 0);
        check("R1 irq after reset", irq, 0);
        check("R1 overrun after reset", ovr, 0);
    endtask

    task automatic do_strobe(input logic [W-1:0] d, input logic en);
        irq_en = en;
        @(negedge clk);
        per_data = d;
        stb_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R10 buf_full not yet updated", buf_full, exp_full);
        @(negedge clk);
        exp_ovr = model_ovr(exp_ovr, exp_full);
        exp_full = 1'b1;
        check("R3 buf_full set on strobe fall", buf_full, 1);
        check("R4 no irq while strobe low", irq, 0);
        repeat ($urandom % 3) @(negedge clk);
        stb_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R10 irq not yet set", irq, 0);
        @(negedge clk);
        if (en) check("R4 irq set on strobe rise", irq, model_irq(en));
        else    check("R5 irq suppressed when disabled", irq, model_irq(en));
        check("R3 buf_full held after strobe rise", buf_full, 1);
        check("R9 overrun flag", ovr, exp_ovr);
        exp_data = d;
        per_data = ~d;
    endtask

    task automatic do_read();
        @(negedge clk);
        rd_n = 1'b0;
        @(negedge clk);
        check("R6 irq cleared on read fall", irq, 0);
        check("R6 buf_full during read", buf_full, exp_full);
        check("R2 data during read", cpu_data, exp_data);
        repeat ($urandom % 3) @(negedge clk);
        rd_n = 1'b1;
        @(negedge clk);
        check("R7 buf_full cleared on read rise", buf_full, 0);
        check("R2 data idle", cpu_data, 0);
        exp_full = 1'b0;
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd5813));
        repeat (3) @(negedge clk);
        check("R1 buf_full in reset", buf_full, 0);
        do_reset();
        do_read();                       // R1 read after reset returns 0, empty read ignored (R7)
        do_strobe(8'hA5, 1'b1);
        do_read();
        do_strobe(8'h3C, 1'b0);          // R5
        do_read();
        do_strobe(8'h11, 1'b1);          // R8 overrun: second strobe overwrites
        do_strobe(8'hE7, 1'b1);
        check("R8 overrun set", ovr, 1);
        do_read();
        check("R9 overrun sticky after read", ovr, 1);
        do_reset();
        check("R9 overrun cleared by reset", ovr, 0);
        for (int i = 0; i < 60; i++) begin
            do_strobe(W'($urandom), 1'($urandom));
            if (($urandom % 4) == 0) do_strobe(W'($urandom), 1'($urandom));
            do_read();
        end
        do_reset();
        do_read();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule